// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a two-flag record of which kind of reset last hit the chip, so that boot firmware can tell a cold power-up from a supply dip from an ordinary reset. One flag is tied to power-on events and one to brown-out events. A reset event drives its flag to 0, and only a software write can set it back to 1.

At boot, firmware reads the register and then writes 1 to both flags. On the next boot it reads again. A power-on flag of 0 means the supply was lost. A brown-out flag of 0, with the power-on flag still 1, means a brown-out occurred. Both flags at 1 point to an ordinary reset from the external pin or the watchdog.

The analog detectors sit outside the block and arrive as single-cycle synchronous pulses. The block also merges every reset source into one active-high reset output.

Top module: `rst_cause_reg`

## Requirements
- R1: While rst_ni is low, both flags are 0 and rd_data_o reads 0. The flags stay 0 after rst_ni is released until something changes them.
- R2: A power-on pulse forces the power-on flag (bit 1) to 0 and the brown-out flag (bit 0) to 0. The brown-out value after power-up is defined as 0.
- R3: A brown-out pulse while bor_en_i is not 00 forces the brown-out flag (bit 0) to 0 and leaves the power-on flag unchanged.
- R4: A pulse on oth_rst_i (pin or watchdog) with no other event or write leaves both flags unchanged.
- R5: A write loads wr_data_i bit 1 into the power-on flag and bit 0 into the brown-out flag. Each flag takes either 1 or 0, and the new value is visible on the cycle after the write edge.
- R6: rd_data_o bits 7 to 2 always read 0. Data written to those bits has no effect.
- R7: While bor_en_i is 00, a brown-out pulse does not change the brown-out flag and does not raise rst_active_o.
- R8: When a reset event and a write fall on the same edge, the event wins for each flag it clears. A flag that the event does not clear takes the written value.
- R9: rst_active_o is high in the same cycle when rst_ni is low, or when any of these is high: the power-on pulse, the other-reset input, or an enabled brown-out pulse. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; initialises both flags to 0 |
| por_pulse_i | input | 1 | Power-on detector event, one cycle |
| bor_pulse_i | input | 1 | Brown-out detector event, one cycle |
| oth_rst_i | input | 1 | Any other reset source (pin, watchdog) |
| bor_en_i | input | 2 | Brown-out detector enable setting; 00 means disabled |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; bit 1 is power-on, bit 0 is brown-out |
| rd_data_o | output | 8 | Register read value |
| por_flag_o | output | 1 | Power-on flag |
| bor_flag_o | output | 1 | Brown-out flag |
| rst_active_o | output | 1 | Combined reset request |

## Verification
A software write and a reset event can land on the same clock edge. In that case each flag must resolve on its own: the event clears the flags it owns, and the other flag takes the written bit. The bench forces this case directly, with a brown-out pulse and a power-on pulse each paired with a write of all ones. It also hits the case often through random stimulus with dense pulses and writes. Each outcome is compared with a bench model that applies the event-over-write rule flag by flag, and the same model covers the detector-disabled case, in which the brown-out pulse must lose to nothing and the write simply takes effect.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;
  localparam int unsigned FLAG_W  = 2;
  localparam int unsigned BOR_BIT = 0;
  localparam int unsigned POR_BIT = 1;

  typedef struct packed {
    logic por;
    logic bor;
    logic oth;
  } rst_evt_t;
endpackage

// File: rtl/rst_src_combiner.sv
module rst_src_combiner
  import rst_cause_pkg::*;
#(
  parameter int unsigned EN_W = 2
) (
  input  logic            rst_ni,
  input  logic            por_pulse_i,
  input  logic            bor_pulse_i,
  input  logic            oth_rst_i,
  input  logic [EN_W-1:0] bor_en_i,
  output rst_evt_t        evt_o,
  output logic            rst_active_o
);
  logic bor_armed;

  assign bor_armed    = |bor_en_i;
  assign evt_o.por    = por_pulse_i;
  assign evt_o.bor    = bor_pulse_i & bor_armed;
  assign evt_o.oth    = oth_rst_i;
  assign rst_active_o = ~rst_ni | evt_o.por | evt_o.bor | evt_o.oth;
endmodule

// File: rtl/rst_flag_cell.sv
module rst_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  // clear beats write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (wr_i)   flag_o <= wr_bit_i;
  end
endmodule

// File: rtl/rst_cause_rdmux.sv
module rst_cause_rdmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FLAG_W = 2
) (
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] rd_data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < FLAG_W) begin : g_flag
      assign rd_data_o[b] = flags_i[b];
    end else begin : g_zero
      assign rd_data_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_cause_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_pulse_i,
  input  logic              bor_pulse_i,
  input  logic              oth_rst_i,
  input  logic [EN_W-1:0]   bor_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              por_flag_o,
  output logic              bor_flag_o,
  output logic              rst_active_o
);
  rst_evt_t          evt;
  logic [FLAG_W-1:0] flag_q;
  logic [FLAG_W-1:0] flag_clr;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:FLAG_W];

  rst_src_combiner #(.EN_W(EN_W)) u_comb (
    .rst_ni      (rst_ni),
    .por_pulse_i (por_pulse_i),
    .bor_pulse_i (bor_pulse_i),
    .oth_rst_i   (oth_rst_i),
    .bor_en_i    (bor_en_i),
    .evt_o       (evt),
    .rst_active_o(rst_active_o)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == POR_BIT) begin : g_por
      assign flag_clr[i] = evt.por;
    end else begin : g_bor
      assign flag_clr[i] = evt.por | evt.bor;
    end
    rst_flag_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (flag_clr[i]),
      .wr_i    (wr_en_i),
      .wr_bit_i(wr_data_i[i]),
      .flag_o  (flag_q[i])
    );
  end

  rst_cause_rdmux #(.DATA_W(DATA_W), .FLAG_W(FLAG_W)) u_rd (
    .flags_i  (flag_q),
    .rd_data_o(rd_data_o)
  );

  assign por_flag_o = flag_q[POR_BIT];
  assign bor_flag_o = flag_q[BOR_BIT];
endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_pulse_i,
  input logic              bor_pulse_i,
  input logic              oth_rst_i,
  input logic [EN_W-1:0]   bor_en_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              por_flag_o,
  input logic              bor_flag_o,
  input logic              rst_active_o
);
  a_r2_por_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_pulse_i |=> (!por_flag_o && !bor_flag_o));

  a_r3_bor_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_pulse_i && bor_en_i != '0 && !por_pulse_i && !wr_en_i)
      |=> (!bor_flag_o && $stable(por_flag_o)));

  a_r4_oth_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oth_rst_i && !por_pulse_i && !bor_pulse_i && !wr_en_i)
      |=> ($stable(por_flag_o) && $stable(bor_flag_o)));

  a_r5_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !por_pulse_i && !(bor_pulse_i && bor_en_i != '0))
      |=> (por_flag_o == $past(wr_data_i[1]) && bor_flag_o == $past(wr_data_i[0])));

  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:2] == '0);

  a_r7_bor_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_pulse_i && bor_en_i == '0 && !por_pulse_i && !wr_en_i)
      |=> $stable(bor_flag_o));

  a_r8_event_over_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bor_pulse_i && bor_en_i != '0 && !por_pulse_i)
      |=> (!bor_flag_o && por_flag_o == $past(wr_data_i[1])));

  a_r9_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_pulse_i || oth_rst_i) |-> rst_active_o);
endmodule

bind rst_cause_reg rst_cause_chk #(.DATA_W(DATA_W), .EN_W(EN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_pulse_i (por_pulse_i),
  .bor_pulse_i (bor_pulse_i),
  .oth_rst_i   (oth_rst_i),
  .bor_en_i    (bor_en_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .por_flag_o  (por_flag_o),
  .bor_flag_o  (bor_flag_o),
  .rst_active_o(rst_active_o)
);

// File: tb/tb_rst_cause_reg.sv
`timescale 1ns/1ps
module tb_rst_cause_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_pulse_i = 1'b0, bor_pulse_i = 1'b0, oth_rst_i = 1'b0;
  logic [1:0] bor_en_i = 2'b01;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       por_flag_o, bor_flag_o, rst_active_o;

  int checks = 0, fails = 0;
  logic [1:0] model = 2'b00;  // {por, bor}

  always #5 clk_i = ~clk_i;

  rst_cause_reg dut (.*);

  function automatic logic [1:0] next_flags(logic [1:0] cur, logic por, logic bor,
                                            logic [1:0] en, logic wr, logic [7:0] d);
    logic [1:0] n;
    logic bor_ok;
    n = cur;
    bor_ok = bor && (en != 2'b00);
    if (wr) n = d[1:0];
    if (bor_ok) n[0] = 1'b0;
    if (por) n = 2'b00;
    return n;
  endfunction

  function automatic logic exp_active(logic rn, logic por, logic bor, logic [1:0] en, logic oth);
    return !rn || por || oth || (bor && en != 2'b00);
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check active combinationally, clock, check flags
  task automatic step(logic por, logic bor, logic [1:0] en, logic oth,
                      logic wr, logic [7:0] d, string req);
    por_pulse_i = por; bor_pulse_i = bor; bor_en_i = en; oth_rst_i = oth;
    wr_en_i = wr; wr_data_i = d;
    #1;
    check(rst_active_o, exp_active(rst_ni, por, bor, en, oth), "R9 rst_active_o");
    model = next_flags(model, por, bor, en, wr, d);
    @(posedge clk_i);
    @(negedge clk_i);
    por_pulse_i = 0; bor_pulse_i = 0; oth_rst_i = 0; wr_en_i = 0;
    check(rd_data_o, {6'b0, model}, req);
    check({por_flag_o, bor_flag_o}, model, req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(rd_data_o, 8'h00, "R1 reset read");
    check(rst_active_o, 1'b1, "R9 active in reset");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rd_data_o, 8'h00, "R1 after release");
    check(rst_active_o, 1'b0, "R9 idle");

    step(0, 0, 2'b01, 0, 1, 8'hFF, "R5/R6 write all ones");
    step(0, 0, 2'b01, 0, 1, 8'hFC, "R5/R6 write zeros, upper ignored");
    step(0, 0, 2'b01, 0, 1, 8'h02, "R5 write por only");
    step(0, 0, 2'b01, 0, 1, 8'h03, "R5 rearm");
    step(1, 0, 2'b01, 0, 0, 8'h00, "R2 power-on pulse");
    step(0, 0, 2'b11, 0, 1, 8'h03, "R5 rearm");
    step(0, 1, 2'b10, 0, 0, 8'h00, "R3 brown-out pulse");
    step(0, 0, 2'b11, 0, 1, 8'h03, "R5 rearm");
    step(0, 0, 2'b11, 1, 0, 8'h00, "R4 other reset keeps flags");
    step(0, 1, 2'b00, 0, 0, 8'h00, "R7 brown-out disabled");
    step(0, 1, 2'b01, 0, 1, 8'hFF, "R8 brown-out beats write");
    step(1, 0, 2'b01, 0, 1, 8'hFF, "R8 power-on beats write");
    step(0, 1, 2'b00, 0, 1, 8'h01, "R7 disabled pulse loses to write");

    for (int i = 0; i < 2000; i++) begin
      logic por, bor, oth, wr;
      logic [1:0] en;
      logic [7:0] d;
      por = ($urandom % 10) == 0;
      bor = ($urandom % 4) == 0;
      oth = ($urandom % 4) == 0;
      wr  = ($urandom % 2) == 0;
      en  = 2'($urandom);
      d   = 8'($urandom);
      step(por, bor, en, oth, wr, d, "R8 random mix");
    end

    // asynchronous reset mid-run
    step(0, 0, 2'b01, 0, 1, 8'h03, "R5 rearm");
    #2 rst_ni = 1'b0;
    #1;
    check(rd_data_o, 8'h00, "R1 async clear");
    check(rst_active_o, 1'b1, "R9 active in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    model = 2'b00;
    @(negedge clk_i);
    check(rd_data_o, 8'h00, "R1 after second release");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule